// File: doc/BRIEF.md
# Saturating Two-Digit Decimal Counter

This block counts upward in decimal on two digit registers, units and tens. It starts at 00, advances by one on every clock cycle in which the increment input is high, and stops at 80. Once it reaches 80 it holds that value and raises a done flag. A push-switch clear input restarts the count from 00. There is no load, preset or down-count path.

All digit registers share one clock edge. The units digit passes its carry to the tens digit through a combinational enable chain, so the digits never pass through transient wrong values. The raw switch input is brought into the clock domain by a two-flop synchroniser before it acts. Each digit drives its own seven-segment bus, so two displays can be wired directly without multiplexing.

Top module: `bcd_sat_counter`

## Requirements
- R1: While `rst_ni` is low, both digits are 0, both segment buses show the pattern for 0 (7'h3F), and `done_o` is low.
- R2: When the clear path is idle and the count is below 80, a cycle with `inc_i` high raises the count by exactly one, visible on the outputs after the next rising edge.
- R3: A cycle with `inc_i` low and the clear path idle leaves the count unchanged.
- R4: The units digit steps 0 through 9, and the step after 9 returns it to 0.
- R5: The tens digit rises by one exactly when the units digit wraps from 9 to 0, and at no other time apart from a clear or reset.
- R6: At 80 the count saturates: further `inc_i` pulses are ignored, the segment buses keep showing 80, and `done_o` stays high.
- R7: `clr_sw_i` passes through a two-flop synchroniser. A high level present before rising edge k clears both digits at edge k+2, and counting resumes once the synchronised clear falls.
- R8: The clear has priority over the increment. While the synchronised clear is high, the count is 00 regardless of `inc_i`.
- R9: The segment buses are active high, with bit 0 = a through bit 6 = g. The digit patterns are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex). `seg_o[6:0]` carries the units digit and `seg_o[13:7]` carries the tens digit.
- R10: `done_o` is high if and only if the count is 80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for all registers |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| clr_sw_i | input | 1 | Raw active-high clear from the push switch |
| inc_i | input | 1 | Count enable, one step per cycle while high |
| seg_o | output | 14 | Seven-segment buses: [6:0] units digit, [13:7] tens digit |
| done_o | output | 1 | High while the count holds at 80 |

## Verification
The segment buses and `done_o` are decoded combinationally from the digit registers. An increment therefore shows up one rising edge after the cycle that carried it. A switch clear shows up at the third edge: two synchroniser stages plus the digit register. An asynchronous reset acts at once. The bench drives its inputs on the falling edge and samples the outputs on the next falling edge. It advances its own reference count at each rising edge, and it keeps a private two-stage copy of the switch level, so the clear is applied to the reference at the same edge at which the design should show it. Directed runs cover the 9-to-10 carry, saturation at 80, a clear together with an increment, and a mid-count reset. A seeded random phase mixes increments with occasional clears.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;

  // Active-high segments, bit 0 = a ... bit 6 = g; codes above 9 blank
  function automatic seg_t bcd_to_seg(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bcdc_sync.sv
module bcdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/bcdc_digit.sv
module bcdc_digit
  import bcdc_pkg::*;
#(
  parameter int LAST = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output bcd_t q_o,
  output logic carry_o
);

  bcd_t q_q;
  bcd_t q_d;
  logic en;
  logic at_last;

  assign at_last = (q_q == BCD_W'(LAST));
  assign en      = clr_i | step_i;

  always_comb begin
    q_d = q_q;
    if (clr_i) begin
      q_d = '0;
    end else if (step_i) begin
      q_d = at_last ? '0 : q_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (en) begin
      q_q <= q_d;
    end
  end

  assign q_o     = q_q;
  assign carry_o = step_i & at_last & ~clr_i;

endmodule

// File: rtl/bcdc_seg7.sv
module bcdc_seg7
  import bcdc_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_o
);

  always_comb begin
    seg_o = bcd_to_seg(digit_i);
  end

endmodule

// File: rtl/bcd_sat_counter.sv
module bcd_sat_counter #(
  parameter int N_DIGITS    = 2,
  parameter int TERM_VALUE  = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_sw_i,
  input  logic                    inc_i,
  output logic [N_DIGITS*7-1:0]   seg_o,
  output logic                    done_o
);

  import bcdc_pkg::*;

  logic                           clr_s;
  logic [N_DIGITS-1:0]            step;
  logic [N_DIGITS-1:0]            carry;
  logic [N_DIGITS-1:0][BCD_W-1:0] digit_q;
  logic [N_DIGITS-1:0]            at_term;
  logic                           unused_top_carry;

  bcdc_sync #(.STAGES(SYNC_STAGES)) clr_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (clr_sw_i),
    .q_o    (clr_s)
  );

  assign step[0] = inc_i & ~done_o;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
    localparam int TERM_D = (TERM_VALUE / (10 ** i)) % 10;

    bcdc_digit #(.LAST(9)) digit_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_s),
      .step_i  (step[i]),
      .q_o     (digit_q[i]),
      .carry_o (carry[i])
    );

    if (i < N_DIGITS - 1) begin : g_chain
      assign step[i+1] = carry[i];
    end

    assign at_term[i] = (digit_q[i] == BCD_W'(TERM_D));

    bcdc_seg7 seg_i (
      .digit_i (digit_q[i]),
      .seg_o   (seg_o[i*SEG_W +: SEG_W])
    );
  end

  assign unused_top_carry = carry[N_DIGITS-1];
  assign done_o           = &at_term;

endmodule

// File: rtl/bcdc_checker.sv
module bcdc_checker #(
  parameter int N_DIGITS = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    clr_s,
  input logic                    inc_i,
  input logic                    done_o,
  input logic [N_DIGITS-1:0][3:0] digit_q,
  input logic [N_DIGITS*7-1:0]   seg_o
);

  logic adv_units;
  assign adv_units = !clr_s && inc_i && !done_o;

  AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_s |=> (digit_q == '0)); // R7

  AST_CLEAR_BEATS_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_s && inc_i) |=> (!done_o && seg_o[6:0] == 7'h3F)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && !inc_i) |=> $stable(digit_q)); // R3

  AST_UNITS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_units && digit_q[0] != 4'd9) |=> (digit_q[0] == 4'($past(digit_q[0]) + 4'd1))); // R2

  AST_UNITS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_units && digit_q[0] == 4'd9) |=> (digit_q[0] == 4'd0)); // R4

  AST_TENS_ONLY_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && !(adv_units && digit_q[0] == 4'd9)) |=> $stable(digit_q[1])); // R5

  AST_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_s) |=> (done_o && $stable(seg_o))); // R6

  AST_UNITS_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o[6:0] != 7'h00)); // R9

  AST_DONE_SHOWS_80: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (seg_o[13:7] == 7'h7F && seg_o[6:0] == 7'h3F)); // R10

endmodule

bind bcd_sat_counter bcdc_checker #(.N_DIGITS(N_DIGITS)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_s   (clr_s),
  .inc_i   (inc_i),
  .done_o  (done_o),
  .digit_q (digit_q),
  .seg_o   (seg_o)
);

// File: tb/bcd_sat_counter_tb_top.sv
`timescale 1ns/1ps
module bcd_sat_counter_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        clr_sw_i;
  logic        inc_i;
  logic [13:0] seg_o;
  logic        done_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int ref_cnt = 0;
  bit sh1 = 0;
  bit sh2 = 0;

  always #10 clk_i = ~clk_i;   // 50 MHz

  bcd_sat_counter dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_sw_i (clr_sw_i),
    .inc_i    (inc_i),
    .seg_o    (seg_o),
    .done_o   (done_o)
  );

  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check_out(input string tag);
    logic [13:0] es;
    logic        ed;
    es = {exp_seg(ref_cnt / 10), exp_seg(ref_cnt % 10)};
    ed = (ref_cnt == 80);
    checks++;
    if (seg_o !== es || done_o !== ed) begin
      failures++;
      $display("FAIL %s: seg=%h done=%b expected seg=%h done=%b (count %0d)",
               tag, seg_o, done_o, es, ed, ref_cnt);
    end
  endtask

  // Drive at falling edge, advance at rising edge, sample at next falling edge
  task automatic cycle(input bit inc, input bit clr, input string tag);
    inc_i    = inc;
    clr_sw_i = clr;
    @(posedge clk_i);
    if (sh2)                      ref_cnt = 0;
    else if (inc && ref_cnt < 80) ref_cnt++;
    sh2 = sh1;
    sh1 = clr;
    @(negedge clk_i);
    check_out(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    ref_cnt = 0; sh1 = 0; sh2 = 0;
    #1;
    check_out("R1");
    @(negedge clk_i);
    check_out("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, actual timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; clr_sw_i = 1'b0; inc_i = 1'b0;
    @(negedge clk_i);
    do_reset();

    // R9 / R4 / R5: step through 0..10 directly
    for (int k = 0; k < 9; k++) cycle(1'b1, 1'b0, "R9");
    cycle(1'b1, 1'b0, "R4");   // 9 -> 10: units wrap
    check_out("R5");
    for (int k = 0; k < 3; k++) cycle(1'b0, 1'b0, "R3");

    // run to 79, then 80
    while (ref_cnt < 79) cycle(1'b1, 1'b0, "R2");
    check_out("R10");          // done must be low at 79
    cycle(1'b1, 1'b0, "R10");  // reaches 80
    for (int k = 0; k < 6; k++) cycle(1'b1, 1'b0, "R6");

    // R7 timing: one-cycle switch pulse, clear lands at third edge
    cycle(1'b1, 1'b1, "R7");
    cycle(1'b1, 1'b0, "R7");
    cycle(1'b1, 1'b0, "R7");
    for (int k = 0; k < 5; k++) cycle(1'b1, 1'b0, "R7");

    // R8: switch held with inc high keeps 00
    for (int k = 0; k < 6; k++) cycle(1'b1, 1'b1, "R8");
    for (int k = 0; k < 4; k++) cycle(1'b1, 1'b0, "R8");

    // R1: asynchronous reset mid count
    for (int k = 0; k < 23; k++) cycle(1'b1, 1'b0, "R2");
    do_reset();

    // Random phase
    for (int k = 0; k < 4000; k++) begin
      bit ri, rc;
      string tag;
      ri = ($urandom_range(0, 99) < 75);
      rc = ($urandom_range(0, 999) < 6);
      if (sh1 || sh2)          tag = "R7";
      else if (ref_cnt == 80)  tag = "R6";
      else if (ri)             tag = "R2";
      else                     tag = "R3";
      cycle(ri, rc, tag);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule